// File: doc/BRIEF.md
# Magnetic tape word buffer control

This block sits between a processor's 36-bit IO register and one selected seven-track tape unit. The processor issues select commands that name a function and a unit. A command that arrives while a read, write or backspace is still running is parked in a one-entry holding slot. It is released to the drive once that operation ends. Toward the drive, the block exchanges 7-bit characters, each made of 6 data bits and one parity bit. It packs six characters read from tape into a word, and it splits a word to be written into six characters. The drive also reports record gaps, end of tape and loss of the unit.

Words move between the processor and the block through a transfer request. The processor waits on that request until the buffer can be served. When the transfer finishes, the block says whether the next instruction should be skipped. A skip signals a clean transfer, and it is withheld whenever any status flag is up. An examine request returns the four status flags in the low bits of the IO word and clears them in the same cycle.

Function codes on `cmd_func` are 0 deselect, 1 read, 2 write, 3 backspace and 4 rewind. Codes 5 to 7 act as deselect. The drive must not deliver more than one character per cycle. The processor issues at most one of transfer and examine at a time.

Top module: `tape_word_ctl`

## Requirements
- R1: A command presented with `cmd_valid` while `cmd_wait` is low is captured, and `cmd_wait` rises after that edge. If no operation is running, then one cycle later `mot_go` pulses with the captured 3-bit function on `mot_func` and the 6-bit unit on `mot_unit`, and `cmd_wait` falls.
- R2: While a read (1), write (2) or backspace (3) is running (`unit_busy` high), a captured command stays held: `cmd_wait` stays high and `mot_go` stays low. The command is issued on the cycle after the running operation ends.
- R3: Rewind (4) and deselect (0) are issued on `mot_go` but leave `unit_busy` low, so the next command is not held.
- R4: While reading, each `rd_strobe` stores `rd_char[5:0]`. After six characters the word is full, and the first character sits in IO bits 35:30. A transfer that finds the word full completes on the next edge: `xfer_done` and `io_load` pulse, and `io_out` holds the word.
- R5: A transfer that finds the read word incomplete, or the write buffer not yet emptied, raises `xfer_stall` until the buffer is ready. The transfer then completes one cycle after the buffer becomes ready. `xfer_done` and `xfer_stall` are never high together.
- R6: While writing, a transfer with an empty write buffer loads `io_in` and completes at once. Each later `wr_take` makes `wr_strobe` pulse with the next 6 bits, most significant first, on `wr_char[5:0]` and an odd-parity bit on `wr_char[6]`.
- R7: `xfer_skip` pulses together with `xfer_done` only when no flag is set, counting flags raised on that same edge.
- R8: A read character whose 7 bits hold an even number of ones sets the parity flag.
- R9: A transfer issued while neither read nor write is running completes on the next edge without stalling, without `io_load` and without a skip. It also sets the read-write check flag.
- R10: A character that arrives while the read word is full and is not being drained is dropped. The dropped character sets read-write check and leaves the held word unchanged.
- R11: A gap during read or backspace sets end of record. End of tape while busy sets end of tape. Loss of the unit while busy sets read-write check. Each of the three ends the running operation, and a gap during a write sets no flag.
- R12: An examine places the flags in `io_out[3:0]` as parity (bit 3), end of tape (bit 2), end of record (bit 1) and read-write check (bit 0). The upper bits are zero and `io_load` pulses. The flags are cleared on the same edge.
- R13: A stalled transfer whose operation ends before the buffer is ready is released one cycle later, with `xfer_done` high, no skip and no `io_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Select command present |
| cmd_func | input | 3 | Command function code |
| cmd_unit | input | 6 | Command unit number |
| cmd_wait | output | 1 | A command is held and not yet issued |
| mot_go | output | 1 | One-cycle pulse issuing a command to the drive |
| mot_func | output | 3 | Function last issued |
| mot_unit | output | 6 | Unit last issued |
| unit_busy | output | 1 | Read, write or backspace in progress |
| rd_strobe | input | 1 | Read character valid |
| rd_char | input | 7 | Read character, parity in bit 6 |
| wr_take | input | 1 | Drive requests the next write character |
| wr_strobe | output | 1 | Write character valid |
| wr_char | output | 7 | Write character, parity in bit 6 |
| tp_gap | input | 1 | Record gap reached |
| tp_eot | input | 1 | End of tape reached |
| tp_unavail | input | 1 | Selected unit lost |
| xfer_req | input | 1 | Word transfer request |
| exam_req | input | 1 | Examine-and-clear flags request |
| io_in | input | 36 | Word from the processor for writing |
| io_out | output | 36 | Word or flag image for the processor |
| io_load | output | 1 | `io_out` valid pulse |
| xfer_stall | output | 1 | Processor must wait |
| xfer_done | output | 1 | Transfer completed pulse |
| xfer_skip | output | 1 | Skip the next instruction |

## Verification
The bench sends a seventh character into a full read word. A design that shifted the seventh character in anyway would return a corrupted word instead of flagging read-write check. It issues a command while a read is running. A controller that did not hold commands would pulse `mot_go` early and switch units in the middle of a record. It kills the unit under a stalled transfer. A design that waited only for a full word would hang the processor forever, and one that skipped there would hide the failure. It also examines flags after a gap during a write, a mistake that would wrongly report end of record.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int FN_W = 3;

  localparam logic [FN_W-1:0] FN_NONE   = 3'd0;
  localparam logic [FN_W-1:0] FN_READ   = 3'd1;
  localparam logic [FN_W-1:0] FN_WRITE  = 3'd2;
  localparam logic [FN_W-1:0] FN_BACK   = 3'd3;
  localparam logic [FN_W-1:0] FN_REWIND = 3'd4;

  // status flags, packed so bit 3 is parity and bit 0 is read-write check
  typedef struct packed {
    logic par;
    logic eot;
    logic eor;
    logic rwc;
  } tpc_flags_t;

  // functions that occupy the control until the drive reports an end
  function automatic logic fn_ties_up(input logic [FN_W-1:0] f);
    return (f == FN_READ) || (f == FN_WRITE) || (f == FN_BACK);
  endfunction
endpackage

// File: rtl/tpc_cmd_queue.sv
module tpc_cmd_queue
  import tpc_pkg::*;
#(
  parameter int UNIT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [FN_W-1:0]   cmd_func,
  input  logic [UNIT_W-1:0] cmd_unit,
  input  logic              op_end,
  output logic              cmd_wait,
  output logic              mot_go,
  output logic [FN_W-1:0]   mot_func,
  output logic [UNIT_W-1:0] mot_unit,
  output logic [FN_W-1:0]   act_func
);
  logic              slot_v;
  logic [FN_W-1:0]   slot_func;
  logic [UNIT_W-1:0] slot_unit;
  logic              busy;

  assign busy     = fn_ties_up(act_func);
  assign cmd_wait = slot_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v    <= 1'b0;
      slot_func <= FN_NONE;
      slot_unit <= '0;
      act_func  <= FN_NONE;
      mot_go    <= 1'b0;
      mot_func  <= FN_NONE;
      mot_unit  <= '0;
    end else begin
      mot_go <= 1'b0;
      if (op_end) act_func <= FN_NONE;
      if (slot_v && !busy) begin
        mot_go   <= 1'b1;
        mot_func <= slot_func;
        mot_unit <= slot_unit;
        act_func <= fn_ties_up(slot_func) ? slot_func : FN_NONE;
        slot_v   <= 1'b0;
      end else if (!slot_v && cmd_valid) begin
        slot_v    <= 1'b1;
        slot_func <= cmd_func;
        slot_unit <= cmd_unit;
      end
    end
  end

  assert_hold_while_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_end) |=> !mot_go);
  assert_rewind_free_R3: assert property (@(posedge clk) disable iff (rst)
    (mot_go && !fn_ties_up(mot_func)) |-> !busy);
  assert_issue_clears_slot_R1: assert property (@(posedge clk) disable iff (rst)
    mot_go |-> !cmd_wait);
endmodule

// File: rtl/tpc_char_pack.sv
module tpc_char_pack #(
  parameter int WORD_W = 36,
  parameter int CHAR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              rd_strobe,
  input  logic [CHAR_W:0]   rd_char,
  input  logic              drain,
  input  logic              wr_take,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_full,
  output logic              wr_empty,
  output logic              wr_strobe,
  output logic [CHAR_W:0]   wr_char,
  output logic              par_err,
  output logic              overrun
);
  localparam int CHARS = WORD_W / CHAR_W;
  localparam int CNT_W = $clog2(CHARS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CHARS);

  logic [CNT_W-1:0]  rd_cnt;
  logic [CNT_W-1:0]  rd_base;
  logic              take_ok;
  logic [CNT_W-1:0]  wr_cnt;
  logic [WORD_W-1:0] wr_buf;
  logic [CHAR_W-1:0] wr_head;

  assign rd_full  = (rd_cnt == FULL);
  assign wr_empty = (wr_cnt == '0);
  assign wr_head  = wr_buf[WORD_W-1 -: CHAR_W];

  always_comb begin
    rd_base = drain ? '0 : rd_cnt;
    take_ok = rd_en && rd_strobe;
    overrun = take_ok && (rd_base == FULL);
    par_err = take_ok && !(^rd_char);
  end

  // read side: characters shift in from the right, first one ends on top
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt  <= '0;
      rd_word <= '0;
    end else if (!rd_en) begin
      rd_cnt <= '0;
    end else begin
      rd_cnt <= rd_base;
      if (take_ok && !overrun) begin
        rd_word <= {rd_word[WORD_W-CHAR_W-1:0], rd_char[CHAR_W-1:0]};
        rd_cnt  <= rd_base + 1'b1;
      end
    end
  end

  // write side: characters leave from the top, odd parity added
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt    <= '0;
      wr_buf    <= '0;
      wr_char   <= '0;
      wr_strobe <= 1'b0;
    end else begin
      wr_strobe <= 1'b0;
      if (!wr_en) begin
        wr_cnt <= '0;
      end else if (load) begin
        wr_buf <= load_word;
        wr_cnt <= FULL;
      end else if (wr_take && !wr_empty) begin
        wr_char   <= {~^wr_head, wr_head};
        wr_strobe <= 1'b1;
        wr_buf    <= wr_buf << CHAR_W;
        wr_cnt    <= wr_cnt - 1'b1;
      end
    end
  end

  assert_rd_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= FULL);
  assert_write_odd_parity_R6: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> (^wr_char));
  assert_overrun_keeps_word_R10: assert property (@(posedge clk) disable iff (rst)
    overrun |=> $stable(rd_word));
endmodule

// File: rtl/tpc_flag_bank.sv
module tpc_flag_bank
  import tpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  tpc_flags_t set,
  input  logic       clr,
  output tpc_flags_t flags
);
  always_ff @(posedge clk) begin
    if (rst)      flags <= '0;
    else if (clr) flags <= set;
    else          flags <= flags | set;
  end

  assert_examine_clears_R12: assert property (@(posedge clk) disable iff (rst)
    (clr && (set == '0)) |=> (flags == '0));
  assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/tape_word_ctl.sv
module tape_word_ctl
  import tpc_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int CHAR_W = 6,
  parameter int UNIT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_func,
  input  logic [UNIT_W-1:0] cmd_unit,
  output logic              cmd_wait,
  output logic              mot_go,
  output logic [2:0]        mot_func,
  output logic [UNIT_W-1:0] mot_unit,
  output logic              unit_busy,
  input  logic              rd_strobe,
  input  logic [CHAR_W:0]   rd_char,
  input  logic              wr_take,
  output logic              wr_strobe,
  output logic [CHAR_W:0]   wr_char,
  input  logic              tp_gap,
  input  logic              tp_eot,
  input  logic              tp_unavail,
  input  logic              xfer_req,
  input  logic              exam_req,
  input  logic [WORD_W-1:0] io_in,
  output logic [WORD_W-1:0] io_out,
  output logic              io_load,
  output logic              xfer_stall,
  output logic              xfer_done,
  output logic              xfer_skip
);
  localparam int FLAG_N = $bits(tpc_flags_t);

  logic [FN_W-1:0]   act_func;
  logic              act_rd, act_wr, act_bk, busy, op_end;
  logic              xpend, x_live, x_inact, x_abort, x_rd, x_wr;
  logic [WORD_W-1:0] rd_word;
  logic              rd_full, wr_empty, par_err, overrun;
  tpc_flags_t        flags, fset;
  logic [FLAG_N-1:0] fl_now;
  logic              skip_ok;

  always_comb begin
    act_rd  = (act_func == FN_READ);
    act_wr  = (act_func == FN_WRITE);
    act_bk  = (act_func == FN_BACK);
    busy    = act_rd || act_wr || act_bk;
    op_end  = busy && (tp_gap || tp_eot || tp_unavail);
    x_live  = xfer_req || xpend;
    x_inact = xfer_req && !xpend && !act_rd && !act_wr;
    x_abort = xpend && !act_rd && !act_wr;
    x_rd    = x_live && act_rd && rd_full;
    x_wr    = x_live && act_wr && wr_empty;
    fset.par = par_err;
    fset.eot = tp_eot && busy;
    fset.eor = tp_gap && (act_rd || act_bk);
    fset.rwc = x_inact || overrun || (tp_unavail && busy);
    fl_now   = flags | fset;
    skip_ok  = (fl_now == '0);
  end

  assign unit_busy  = busy;
  assign xfer_stall = xpend;

  tpc_cmd_queue #(.UNIT_W(UNIT_W)) u_cmd (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_func(cmd_func), .cmd_unit(cmd_unit),
    .op_end(op_end), .cmd_wait(cmd_wait),
    .mot_go(mot_go), .mot_func(mot_func), .mot_unit(mot_unit),
    .act_func(act_func)
  );

  tpc_char_pack #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) u_pack (
    .clk(clk), .rst(rst),
    .rd_en(act_rd), .wr_en(act_wr),
    .rd_strobe(rd_strobe), .rd_char(rd_char), .drain(x_rd),
    .wr_take(wr_take), .load(x_wr), .load_word(io_in),
    .rd_word(rd_word), .rd_full(rd_full), .wr_empty(wr_empty),
    .wr_strobe(wr_strobe), .wr_char(wr_char),
    .par_err(par_err), .overrun(overrun)
  );

  tpc_flag_bank u_flags (
    .clk(clk), .rst(rst), .set(fset), .clr(exam_req), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xpend     <= 1'b0;
      xfer_done <= 1'b0;
      xfer_skip <= 1'b0;
      io_load   <= 1'b0;
      io_out    <= '0;
    end else begin
      xfer_done <= 1'b0;
      xfer_skip <= 1'b0;
      io_load   <= 1'b0;
      if (x_inact || x_abort) begin
        xfer_done <= 1'b1;
        xpend     <= 1'b0;
      end else if (x_rd) begin
        xfer_done <= 1'b1;
        xfer_skip <= skip_ok;
        io_out    <= rd_word;
        io_load   <= 1'b1;
        xpend     <= 1'b0;
      end else if (x_wr) begin
        xfer_done <= 1'b1;
        xfer_skip <= skip_ok;
        xpend     <= 1'b0;
      end else if (x_live) begin
        xpend <= 1'b1;
      end
      if (exam_req && !x_rd) begin
        io_out  <= {{(WORD_W-FLAG_N){1'b0}}, flags};
        io_load <= 1'b1;
      end
    end
  end

  assert_skip_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_skip |-> xfer_done);
  assert_stall_done_apart_R5: assert property (@(posedge clk) disable iff (rst)
    !(xfer_done && xfer_stall));
  assert_inactive_transfer_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_stall && !busy && !exam_req) |=>
      (xfer_done && !xfer_skip && !io_load && !xfer_stall));
  assert_abort_release_R13: assert property (@(posedge clk) disable iff (rst)
    (xfer_stall && !xfer_req && !busy) |=> (xfer_done && !xfer_skip));
endmodule

// File: tb/tape_word_ctl_test.sv
module tape_word_ctl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid = 0;
  logic [2:0]  cmd_func = 0;
  logic [5:0]  cmd_unit = 0;
  logic        cmd_wait, mot_go, unit_busy;
  logic [2:0]  mot_func;
  logic [5:0]  mot_unit;
  logic        rd_strobe = 0;
  logic [6:0]  rd_char = 0;
  logic        wr_take = 0;
  logic        wr_strobe;
  logic [6:0]  wr_char;
  logic        tp_gap = 0, tp_eot = 0, tp_unavail = 0;
  logic        xfer_req = 0, exam_req = 0;
  logic [35:0] io_in = 0;
  logic [35:0] io_out;
  logic        io_load, xfer_stall, xfer_done, xfer_skip;

  int checks = 0;
  int fails = 0;
  logic [3:0] fl;

  always #10 clk = ~clk;

  tape_word_ctl uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .cmd_unit(cmd_unit), .cmd_wait(cmd_wait), .mot_go(mot_go),
    .mot_func(mot_func), .mot_unit(mot_unit), .unit_busy(unit_busy),
    .rd_strobe(rd_strobe), .rd_char(rd_char), .wr_take(wr_take),
    .wr_strobe(wr_strobe), .wr_char(wr_char), .tp_gap(tp_gap),
    .tp_eot(tp_eot), .tp_unavail(tp_unavail), .xfer_req(xfer_req),
    .exam_req(exam_req), .io_in(io_in), .io_out(io_out), .io_load(io_load),
    .xfer_stall(xfer_stall), .xfer_done(xfer_done), .xfer_skip(xfer_skip)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] f, input logic [5:0] u);
    cmd_valid = 1; cmd_func = f; cmd_unit = u;
    cyc();
    cmd_valid = 0;
  endtask

  task automatic send(input logic [5:0] d, input logic bad);
    rd_char = {(~^d) ^ bad, d};
    rd_strobe = 1;
    cyc();
    rd_strobe = 0;
  endtask

  task automatic xfer();
    xfer_req = 1;
    cyc();
    xfer_req = 0;
  endtask

  task automatic exam(output logic [3:0] f);
    exam_req = 1;
    cyc();
    exam_req = 0;
    check("R12 exam load", io_load, 1);
    check("R12 exam upper zero", io_out[35:4], 0);
    f = io_out[3:0];
  endtask

  task automatic pulse_gap();  tp_gap = 1;  cyc(); tp_gap = 0;  endtask
  task automatic pulse_eot();  tp_eot = 1;  cyc(); tp_eot = 0;  endtask
  task automatic pulse_lost(); tp_unavail = 1; cyc(); tp_unavail = 0; endtask

  function automatic logic [35:0] word_of(input logic [5:0] b);
    return {b, b + 6'd1, b + 6'd2, b + 6'd3, b + 6'd4, b + 6'd5};
  endfunction

  task automatic send_word(input logic [5:0] b, input int bad_at);
    for (int i = 0; i < 6; i++) send(b + 6'(i), i == bad_at);
  endtask

  task automatic t_reset();
    check("R1 reset cmd_wait", cmd_wait, 0);
    check("R2 reset busy", unit_busy, 0);
    check("R5 reset stall", xfer_stall, 0);
    check("R4 reset io_out", io_out, 0);
  endtask

  task automatic t_select();
    issue(3'd1, 6'd5);
    check("R1 held one cycle", cmd_wait, 1);
    check("R1 no early go", mot_go, 0);
    cyc();
    check("R1 go", mot_go, 1);
    check("R1 func", mot_func, 3'd1);
    check("R1 unit", mot_unit, 6'd5);
    check("R1 wait cleared", cmd_wait, 0);
    check("R2 busy on read", unit_busy, 1);
  endtask

  task automatic t_read();
    send_word(6'o10, -1);
    xfer();
    check("R4 done", xfer_done, 1);
    check("R4 load", io_load, 1);
    check("R4 word", io_out, word_of(6'o10));
    check("R7 skip clean", xfer_skip, 1);
  endtask

  task automatic t_stall();
    xfer();
    check("R5 stall", xfer_stall, 1);
    check("R5 no done", xfer_done, 0);
    for (int i = 0; i < 5; i++) send(6'o41 + 6'(i), 1'b0);
    check("R5 still stalled", xfer_stall, 1);
    send(6'o46, 1'b0);
    check("R5 not yet done", xfer_done, 0);
    cyc();
    check("R5 released", xfer_done, 1);
    check("R5 stall low", xfer_stall, 0);
    check("R4 stalled word", io_out, word_of(6'o41));
  endtask

  task automatic t_parity();
    send_word(6'o20, 3);
    xfer();
    check("R7 no skip on parity", xfer_skip, 0);
    check("R8 done", xfer_done, 1);
    exam(fl);
    check("R8 parity flag", fl, 4'b1000);
    exam(fl);
    check("R12 cleared", fl, 4'b0000);
  endtask

  task automatic t_overrun();
    send_word(6'o30, -1);
    send(6'o77, 1'b0);
    xfer();
    check("R10 word kept", io_out, word_of(6'o30));
    check("R10 no skip", xfer_skip, 0);
    exam(fl);
    check("R10 rwc", fl, 4'b0001);
  endtask

  task automatic t_hold();
    issue(3'd2, 6'd2);
    for (int i = 0; i < 3; i++) begin
      check("R2 held", cmd_wait, 1);
      check("R2 no go", mot_go, 0);
      cyc();
    end
    pulse_gap();
    check("R11 gap ends read", unit_busy, 0);
    check("R2 still held", cmd_wait, 1);
    cyc();
    check("R2 go after end", mot_go, 1);
    check("R2 func", mot_func, 3'd2);
    check("R2 unit", mot_unit, 6'd2);
    exam(fl);
    check("R11 eor on read gap", fl, 4'b0010);
  endtask

  task automatic t_write();
    logic [35:0] w;
    w = 36'h9_A5C3_1E7F;
    io_in = w;
    xfer();
    check("R6 done", xfer_done, 1);
    check("R6 no load", io_load, 0);
    check("R7 skip", xfer_skip, 1);
    for (int i = 0; i < 6; i++) begin
      logic [5:0] d;
      d = w[35 - 6*i -: 6];
      wr_take = 1;
      cyc();
      wr_take = 0;
      check("R6 strobe", wr_strobe, 1);
      check("R6 char", wr_char, {~^d, d});
    end
  endtask

  task automatic t_inactive();
    pulse_gap();
    check("R11 gap ends write", unit_busy, 0);
    xfer();
    check("R9 done", xfer_done, 1);
    check("R9 no stall", xfer_stall, 0);
    check("R9 no load", io_load, 0);
    check("R9 no skip", xfer_skip, 0);
    exam(fl);
    check("R9 rwc only", fl, 4'b0001);
  endtask

  task automatic t_back();
    issue(3'd3, 6'd1);
    cyc();
    check("R11 back busy", unit_busy, 1);
    pulse_gap();
    exam(fl);
    check("R11 eor on backspace", fl, 4'b0010);
    issue(3'd3, 6'd1);
    cyc();
    pulse_eot();
    check("R11 eot ends", unit_busy, 0);
    exam(fl);
    check("R11 eot flag", fl, 4'b0100);
  endtask

  task automatic t_rewind();
    issue(3'd4, 6'd7);
    cyc();
    check("R3 go", mot_go, 1);
    check("R3 func", mot_func, 3'd4);
    check("R3 not busy", unit_busy, 0);
    issue(3'd1, 6'd3);
    cyc();
    check("R3 next not held", mot_go, 1);
    check("R3 read busy", unit_busy, 1);
  endtask

  task automatic t_lost();
    xfer();
    check("R13 stalled", xfer_stall, 1);
    pulse_lost();
    check("R13 not yet", xfer_done, 0);
    cyc();
    check("R13 released", xfer_done, 1);
    check("R13 no skip", xfer_skip, 0);
    check("R13 no load", io_load, 0);
    exam(fl);
    check("R11 lost unit rwc", fl, 4'b0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) cyc();
    rst = 0;
    cyc();
    t_reset();
    t_select();
    t_read();
    t_stall();
    t_parity();
    t_overrun();
    t_hold();
    t_write();
    t_inactive();
    t_back();
    t_rewind();
    t_lost();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule